// File: doc/BRIEF.md
# ALU Operation Decoder

This block is the second stage of a split instruction decode. The main decoder sees only the opcode and passes on a 3-bit operation class. This block combines that class with the 6-bit function field of register-register instructions and produces a 3-bit ALU operation code. The split keeps the opcode decoder to 64 input combinations. Folding the function field into it would raise that to about four thousand.

The output code drives a ripple ALU. Bit 2 inverts the second operand and feeds the carry in. Bits 1:0 select the result: 00 is bitwise and, 01 is bitwise or, 10 is the adder sum, 11 is the less-than flag. Three class values give a fixed operation and ignore the function field. These are address add, compare subtract and immediate or. Class 100 hands the choice to the function field. All other class values fall back to add.

The block is purely combinational. Outputs follow the inputs within the same cycle, with no storage.

Top module: `alu_op_decoder`

## Requirements
- R1: When `op_class` is 000, `alu_ctl` is 010 (add) for every value of `func`.
- R2: When `op_class` is 001, `alu_ctl` is 110 (subtract) for every value of `func`.
- R3: When `op_class` is 010, `alu_ctl` is 001 (or) for every value of `func`.
- R4: When `op_class` is 011, 101, 110 or 111, `alu_ctl` is 010 (add) for every value of `func`.
- R5: When `op_class` is 100, the function codes map as follows: 100000 (add) gives 010, 100010 (subtract) gives 110, 100100 (and) gives 000, 100101 (or) gives 001, and 101010 (set on less than) gives 111.
- R6: When `op_class` is 100, `alu_ctl[2]` is 1 exactly when `func[2:0]` is 010. `func[3]` has no effect on this bit.
- R7: When `op_class` is 100, `alu_ctl[1]` is the inverse of `func[2]`.
- R8: When `op_class` is 100, `alu_ctl[0]` is 1 exactly when `func[3:0]` is 0101 or 1010.
- R9: `func[5:4]` never changes any output.
- R10: `b_invert` always equals `alu_ctl[2]`, and `res_sel` always equals `alu_ctl[1:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 3 | Operation class from the opcode decoder |
| func | input | 6 | Function field of the current instruction |
| alu_ctl | output | 3 | ALU operation code |
| b_invert | output | 1 | Second-operand invert and carry-in control |
| res_sel | output | 2 | ALU result selector (and, or, sum, less) |

## Verification
The checks assume that `op_class` and `func` are two-state values that settle before the outputs are read. The function field is relied on only when the class is 100. The stimulus holds each input pair stable for a full clock period and reads the outputs at the falling edge. It sweeps all 512 combinations of class and function, so it covers the unlisted class values and the function codes with no defined operation. A separate pass toggles `func[5:4]` for every low pattern and compares the outputs.

// File: rtl/alu_op_pkg.sv
`timescale 1ns/1ps
package alu_op_pkg;
    localparam int CLASS_W = 3;
    localparam int FUNC_W  = 6;
    localparam int CTL_W   = 3;
    localparam int SEL_W   = CTL_W - 1;
    localparam int LOW_W   = 4;

    typedef enum logic [CTL_W-1:0] {
        CTL_AND = 3'b000,
        CTL_OR  = 3'b001,
        CTL_ADD = 3'b010,
        CTL_SUB = 3'b110,
        CTL_SLT = 3'b111
    } alu_ctl_e;

    typedef enum logic [CLASS_W-1:0] {
        CLS_ADDR = 3'b000,
        CLS_CMP  = 3'b001,
        CLS_ORI  = 3'b010,
        CLS_FUNC = 3'b100
    } op_class_e;
endpackage

// File: rtl/alu_fixed_decode.sv
`timescale 1ns/1ps
module alu_fixed_decode
    import alu_op_pkg::*;
(
    input  logic [CLASS_W-1:0] op_class,
    output logic [CTL_W-1:0]   fixed_ctl,
    output logic               use_func
);
    always_comb begin
        fixed_ctl = CTL_ADD;
        use_func  = 1'b0;
        case (op_class)
            CLS_ADDR: fixed_ctl = CTL_ADD;
            CLS_CMP:  fixed_ctl = CTL_SUB;
            CLS_ORI:  fixed_ctl = CTL_OR;
            CLS_FUNC: use_func  = 1'b1;
            default:  fixed_ctl = CTL_ADD;
        endcase
    end
endmodule

// File: rtl/alu_func_decode.sv
`timescale 1ns/1ps
module alu_func_decode
    import alu_op_pkg::*;
(
    input  logic [FUNC_W-1:0] func,
    output logic [CTL_W-1:0]  func_ctl
);
    logic [LOW_W-1:0] low;
    logic             inv_b;
    logic             sel_hi;
    logic             sel_lo;

    assign low = func[LOW_W-1:0];

    always_comb begin
        unique case (low[2:0])
            3'b010:  inv_b = 1'b1;
            default: inv_b = 1'b0;
        endcase
    end

    assign sel_hi = ~low[2];

    always_comb begin
        unique case (low)
            4'b0101, 4'b1010: sel_lo = 1'b1;
            default:          sel_lo = 1'b0;
        endcase
    end

    assign func_ctl = {inv_b, sel_hi, sel_lo};
endmodule

// File: rtl/alu_op_decoder.sv
`timescale 1ns/1ps
module alu_op_decoder
    import alu_op_pkg::*;
(
    input  logic [CLASS_W-1:0] op_class,
    input  logic [FUNC_W-1:0]  func,
    output logic [CTL_W-1:0]   alu_ctl,
    output logic               b_invert,
    output logic [SEL_W-1:0]   res_sel
);
    logic [CTL_W-1:0] fixed_ctl;
    logic [CTL_W-1:0] func_ctl;
    logic             use_func;

    alu_fixed_decode u_fixed (
        .op_class  (op_class),
        .fixed_ctl (fixed_ctl),
        .use_func  (use_func)
    );

    alu_func_decode u_func (
        .func     (func),
        .func_ctl (func_ctl)
    );

    assign alu_ctl  = use_func ? func_ctl : fixed_ctl;
    assign b_invert = alu_ctl[CTL_W-1];
    assign res_sel  = alu_ctl[SEL_W-1:0];
endmodule

// File: rtl/alu_op_decoder_chk.sv
`timescale 1ns/1ps
module alu_op_decoder_chk
    import alu_op_pkg::*;
(
    input logic [CLASS_W-1:0] op_class,
    input logic [FUNC_W-1:0]  func,
    input logic [CTL_W-1:0]   alu_ctl,
    input logic               b_invert,
    input logic [SEL_W-1:0]   res_sel
);
    always_comb begin
        if (op_class == 3'b000) AST_ADDR_ADD: assert (alu_ctl == 3'b010); // R1
        if (op_class == 3'b001) AST_CMP_SUB:  assert (alu_ctl == 3'b110); // R2
        if (op_class == 3'b010) AST_IMM_OR:   assert (alu_ctl == 3'b001); // R3
        if (op_class == 3'b011 || op_class[2:1] == 2'b11 || op_class == 3'b101)
            AST_OTHER_ADD: assert (alu_ctl == 3'b010); // R4
        if (op_class == 3'b100 && func == 6'b101010)
            AST_SLT_CODE: assert (alu_ctl == 3'b111); // R5
        if (op_class == 3'b100)
            AST_BINV_BIT: assert (alu_ctl[2] == (func[2:0] == 3'b010)); // R6
        if (op_class == 3'b100)
            AST_SEL_HI: assert (alu_ctl[1] != func[2]); // R7
        if (op_class == 3'b100)
            AST_SEL_LO: assert (alu_ctl[0] == (func[3:0] == 4'b0101 || func[3:0] == 4'b1010)); // R8
        AST_FIELDS: assert (b_invert == alu_ctl[2] && res_sel == alu_ctl[1:0]); // R10
    end
endmodule

bind alu_op_decoder alu_op_decoder_chk u_chk (
    .op_class (op_class),
    .func     (func),
    .alu_ctl  (alu_ctl),
    .b_invert (b_invert),
    .res_sel  (res_sel)
);

// File: tb/tb_alu_op_decoder.sv
`timescale 1ns/1ps
module tb_alu_op_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_class = 3'b000;
    logic [5:0] func = 6'b000000;
    logic [2:0] alu_ctl;
    logic       b_invert;
    logic [1:0] res_sel;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    alu_op_decoder dut (
        .op_class (op_class),
        .func     (func),
        .alu_ctl  (alu_ctl),
        .b_invert (b_invert),
        .res_sel  (res_sel)
    );

    function automatic int ref_ctl(int cls, int fn);
        int b2, b1, b0;
        if (cls == 4) begin
            b2 = ((fn % 8) == 2) ? 1 : 0;
            b1 = (((fn / 4) % 2) == 0) ? 1 : 0;
            b0 = ((fn % 16) == 5 || (fn % 16) == 10) ? 1 : 0;
            return b2 * 4 + b1 * 2 + b0;
        end
        if (cls == 1) return 6;
        if (cls == 2) return 1;
        return 2;
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (class=%0d func=%0d)",
                     tag, act, exp, op_class, func);
        end
    endtask

    task automatic apply(int cls, int fn);
        @(posedge clk);
        #2;
        op_class = cls[2:0];
        func     = fn[5:0];
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", int'(alu_ctl), 2);
        rst_n = 1'b1;

        // R5: named function codes
        apply(4, 6'b100000); check("R5 add", int'(alu_ctl), 2);
        apply(4, 6'b100010); check("R5 sub", int'(alu_ctl), 6);
        apply(4, 6'b100100); check("R5 and", int'(alu_ctl), 0);
        apply(4, 6'b100101); check("R5 or",  int'(alu_ctl), 1);
        apply(4, 6'b101010); check("R5 slt", int'(alu_ctl), 7);

        // Full sweep against the reference model
        for (int c = 0; c < 8; c++) begin
            for (int f = 0; f < 64; f++) begin
                string tag;
                apply(c, f);
                case (c)
                    0: tag = "R1";
                    1: tag = "R2";
                    2: tag = "R3";
                    4: tag = "R6 R7 R8";
                    default: tag = "R4";
                endcase
                check(tag, int'(alu_ctl), ref_ctl(c, f));
                check("R10", int'({b_invert, res_sel}), int'(alu_ctl));
            end
        end

        // R9: upper function bits have no effect
        for (int c = 0; c < 8; c++) begin
            for (int f = 0; f < 16; f++) begin
                int base;
                apply(c, f);
                base = int'(alu_ctl);
                for (int h = 1; h < 4; h++) begin
                    apply(c, h * 16 + f);
                    check("R9", int'(alu_ctl), base);
                end
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule